// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

The block stores a small two-bit-per-pixel cursor image, a three-entry cursor color table, a cursor mode and a 12-bit X/Y position. It merges the cursor into a live pixel stream. A byte-wide host write port loads all of this state. On the video side the block takes the current pixel coordinate, a blank flag and the underlying 24-bit pixel color. One clock later it outputs either that pixel, one of the two cursor colors, or the overscan color.

The image is held as two bit planes stored back to back. The upper plane is an opacity mask and the lower plane picks between the background and foreground colors. The position register names the pixel just past the cursor's lower-right corner, offset by the cursor size. Because of this offset a cursor that hangs off the top or left edge of the screen can still be placed. An interlace option drops the lowest bit of the Y position.

Top module: `hwcur_top`

## Requirements
- R1: After reset the mode is 0 (cursor off), the position is 0 and all color entries are 0. The output is therefore the input pixel, or 0 while blank is high.
- R2: Host select 0 loads the image pointer with the written byte, upper pointer bits cleared. Select 1 stores the byte at the pointer and then increments the pointer, wrapping from 1023 to 0. Byte b belongs to plane b[9], row b[8:3] and column group b[2:0]. Bit 7 of a byte is the leftmost of its 8 pixels.
- R3: Host select 2 sets the color pointer to entry wdata[1:0], with value 3 treated as 0, and restarts at red. Each select 3 write stores red, then green, then blue, and then moves on to the next entry (0, 1, 2, then back to 0). The output color is {red, green, blue}.
- R4: Host select 4 writes the mode register. Bits [1:0] are the mode, and bit 3 is interlace. Only mode 3 draws the cursor; modes 0, 1 and 2 pass the pixel through.
- R5: In mode 3, a mask bit (plane 1) of 0 shows the pixel. Mask 1 with color bit (plane 0) of 0 shows entry 1, the background. Mask 1 with color bit 1 shows entry 2, the foreground.
- R6: On each axis the cursor covers screen coordinates from position-64 to position-1. Cursor column 0 and row 0 fall at position-64. Pixels outside this window show the input pixel.
- R7: Selects 5 and 7 stage the X and Y low bytes. Selects 6 and 8 commit {wdata[3:0], staged low byte} to X and Y. A low-byte write alone leaves the drawn position unchanged.
- R8: With interlace set, bit 0 of the Y position is treated as 0.
- R9: While blank is high the output is entry 0, the overscan color, whatever the cursor state.
- R10: The output reflects the inputs presented one clock earlier.
- R11: A position below 64 on an axis draws only the visible part of the cursor. The column and row offsets stay correct, so screen x=0 shows cursor column 64-position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 4 | Host register select (0 to 8) |
| host_wdata | input | 8 | Host write data |
| pix_x | input | 12 | Current pixel X coordinate |
| pix_y | input | 12 | Current pixel Y coordinate |
| pix_blank | input | 1 | Blanking interval flag |
| pix_rgb | input | 24 | Underlying pixel color |
| out_rgb | output | 24 | Registered overlay output color |

## Verification
The bench builds the block with its default 64-pixel cursor. This makes a full 1024-byte load, and the pointer wrap to byte 0, short enough to run directly. It sweeps complete windows around the cursor edges against a model that reads every image bit. The default 12-bit coordinates allow positions below 64, so the partly off-screen case is reached alongside a mid-screen placement with an odd Y position.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

    localparam int POS_W = 12;

    typedef enum logic [3:0] {
        SEL_IMG_ADDR = 4'd0,
        SEL_IMG_DATA = 4'd1,
        SEL_COL_ADDR = 4'd2,
        SEL_COL_DATA = 4'd3,
        SEL_MODE     = 4'd4,
        SEL_XLO      = 4'd5,
        SEL_XHI      = 4'd6,
        SEL_YLO      = 4'd7,
        SEL_YHI      = 4'd8
    } host_sel_e;

    localparam logic [1:0] MODE_X11 = 2'd3;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic [1:0] mode;
        logic       interlace;
    } ctrl_t;

    function automatic logic [1:0] next_entry(input logic [1:0] idx);
        return (idx == 2'd2) ? 2'd0 : idx + 2'd1;
    endfunction

    function automatic logic [1:0] clamp_entry(input logic [1:0] idx);
        return (idx == 2'd3) ? 2'd0 : idx;
    endfunction

endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
    import hwcur_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  host_sel_e         sel,
    input  logic [7:0]        wdata,
    output logic              img_we,
    output logic [AW-1:0]     img_addr,
    output logic [7:0]        img_wdata,
    output ctrl_t             ctrl,
    output logic [POS_W-1:0]  pos_x,
    output logic [POS_W-1:0]  pos_y,
    output rgb_t              col_ovs,
    output rgb_t              col_bg,
    output rgb_t              col_fg
);

    logic [AW-1:0] img_ptr;
    logic [7:0]    x_lo, y_lo;
    logic [1:0]    cidx, comp;
    rgb_t          tab [3];

    assign img_we    = we && (sel == SEL_IMG_DATA);
    assign img_addr  = img_ptr;
    assign img_wdata = wdata;
    assign col_ovs   = tab[0];
    assign col_bg    = tab[1];
    assign col_fg    = tab[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            img_ptr <= '0;
            x_lo    <= '0;
            y_lo    <= '0;
            pos_x   <= '0;
            pos_y   <= '0;
            ctrl    <= '0;
            cidx    <= '0;
            comp    <= '0;
            for (int i = 0; i < 3; i++) tab[i] <= '0;
        end else if (we) begin
            case (sel)
                SEL_IMG_ADDR: img_ptr <= AW'(wdata);
                SEL_IMG_DATA: img_ptr <= img_ptr + 1'b1;
                SEL_COL_ADDR: begin
                    cidx <= clamp_entry(wdata[1:0]);
                    comp <= 2'd0;
                end
                SEL_COL_DATA: begin
                    case (comp)
                        2'd0:    tab[cidx].r <= wdata;
                        2'd1:    tab[cidx].g <= wdata;
                        default: tab[cidx].b <= wdata;
                    endcase
                    if (comp == 2'd2) begin
                        comp <= 2'd0;
                        cidx <= next_entry(cidx);
                    end else begin
                        comp <= comp + 2'd1;
                    end
                end
                SEL_MODE: begin
                    ctrl.mode      <= wdata[1:0];
                    ctrl.interlace <= wdata[3];
                end
                SEL_XLO: x_lo  <= wdata;
                SEL_XHI: pos_x <= {wdata[3:0], x_lo};
                SEL_YLO: y_lo  <= wdata;
                SEL_YHI: pos_y <= {wdata[3:0], y_lo};
                default: ;
            endcase
        end
    end

    // R2: each data write advances the image pointer by one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_IMG_DATA) |=> img_ptr == $past(img_ptr) + 1'b1);

    // R7: X position changes only on a high-byte write
    a_r7_hold_x: assert property (@(posedge clk) disable iff (rst)
        !(we && sel == SEL_XHI) |=> $stable(pos_x));

    // R7: Y position changes only on a high-byte write
    a_r7_hold_y: assert property (@(posedge clk) disable iff (rst)
        !(we && sel == SEL_YHI) |=> $stable(pos_y));

    // R3: after the blue byte the component returns to red
    a_r3_comp_wrap: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_COL_DATA && comp == 2'd2) |=> comp == 2'd0);

endmodule

// File: rtl/hwcur_plane_ram.sv
module hwcur_plane_ram #(
    parameter int AW     = 10,
    parameter int PLANES = 2
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  logic [7:0]                  wdata,
    input  logic [PLANES-1:0][AW-1:0]   rd_addr,
    output logic [PLANES-1:0][7:0]      rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end

endmodule

// File: rtl/hwcur_mixer.sv
module hwcur_mixer
    import hwcur_pkg::*;
#(
    parameter int CUR_DIM = 64,
    parameter int IDX_W   = $clog2(CUR_DIM),
    parameter int AW      = 2 * IDX_W - 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [POS_W-1:0]      pix_x,
    input  logic [POS_W-1:0]      pix_y,
    input  logic                  pix_blank,
    input  rgb_t                  pix_rgb,
    input  ctrl_t                 ctrl,
    input  logic [POS_W-1:0]      pos_x,
    input  logic [POS_W-1:0]      pos_y,
    input  rgb_t                  col_ovs,
    input  rgb_t                  col_bg,
    input  rgb_t                  col_fg,
    output logic [1:0][AW-1:0]    rd_addr,
    input  logic [1:0][7:0]       rd_data,
    output rgb_t                  out_rgb
);

    localparam logic [POS_W+1:0] OFF_V = (POS_W + 2)'(CUR_DIM);

    logic [POS_W-1:0] py_eff;
    logic [POS_W+1:0] rel_x, rel_y;
    logic [IDX_W-1:0] col, row;
    logic             hit, mask_bit, color_bit;
    rgb_t             nxt;

    assign py_eff = ctrl.interlace ? {pos_y[POS_W-1:1], 1'b0} : pos_y;
    assign rel_x  = {2'b00, pix_x} + OFF_V - {2'b00, pos_x};
    assign rel_y  = {2'b00, pix_y} + OFF_V - {2'b00, py_eff};
    assign hit    = (rel_x[POS_W+1:IDX_W] == '0) && (rel_y[POS_W+1:IDX_W] == '0);
    assign col    = rel_x[IDX_W-1:0];
    assign row    = rel_y[IDX_W-1:0];

    for (genvar p = 0; p < 2; p++) begin : g_addr
        assign rd_addr[p] = {1'(p), row, col[IDX_W-1:3]};
    end

    assign mask_bit  = rd_data[1][~col[2:0]];
    assign color_bit = rd_data[0][~col[2:0]];

    always_comb begin
        if (pix_blank)
            nxt = col_ovs;
        else if (ctrl.mode == MODE_X11 && hit && mask_bit)
            nxt = color_bit ? col_fg : col_bg;
        else
            nxt = pix_rgb;
    end

    always_ff @(posedge clk) begin
        if (rst) out_rgb <= '0;
        else     out_rgb <= nxt;
    end

    // R9: blank forces overscan color one cycle later
    a_r9_blank_overscan: assert property (@(posedge clk) disable iff (rst)
        pix_blank |=> out_rgb == $past(col_ovs));

    // R4: a mode other than 3 passes the pixel through
    a_r4_off_passthru: assert property (@(posedge clk) disable iff (rst)
        (!pix_blank && ctrl.mode != MODE_X11) |=> out_rgb == $past(pix_rgb));

    // R6: a pixel outside the cursor window passes through
    a_r6_outside: assert property (@(posedge clk) disable iff (rst)
        (!pix_blank && !hit) |=> out_rgb == $past(pix_rgb));

endmodule

// File: rtl/hwcur_top.sv
module hwcur_top
    import hwcur_pkg::*;
#(
    parameter int CUR_DIM = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [3:0]  host_sel,
    input  logic [7:0]  host_wdata,
    input  logic [11:0] pix_x,
    input  logic [11:0] pix_y,
    input  logic        pix_blank,
    input  logic [23:0] pix_rgb,
    output logic [23:0] out_rgb
);

    localparam int IDX_W = $clog2(CUR_DIM);
    localparam int AW    = 2 * IDX_W - 2;

    logic             img_we;
    logic [AW-1:0]    img_addr;
    logic [7:0]       img_wdata;
    ctrl_t            ctrl;
    logic [POS_W-1:0] pos_x, pos_y;
    rgb_t             col_ovs, col_bg, col_fg, mix_out;
    logic [1:0][AW-1:0] rd_addr;
    logic [1:0][7:0]    rd_data;

    hwcur_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (host_we),
        .sel       (host_sel_e'(host_sel)),
        .wdata     (host_wdata),
        .img_we    (img_we),
        .img_addr  (img_addr),
        .img_wdata (img_wdata),
        .ctrl      (ctrl),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .col_ovs   (col_ovs),
        .col_bg    (col_bg),
        .col_fg    (col_fg)
    );

    hwcur_plane_ram #(.AW(AW), .PLANES(2)) u_ram (
        .clk     (clk),
        .we      (img_we),
        .waddr   (img_addr),
        .wdata   (img_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    hwcur_mixer #(.CUR_DIM(CUR_DIM), .IDX_W(IDX_W), .AW(AW)) u_mix (
        .clk       (clk),
        .rst       (rst),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_blank (pix_blank),
        .pix_rgb   (rgb_t'(pix_rgb)),
        .ctrl      (ctrl),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .col_ovs   (col_ovs),
        .col_bg    (col_bg),
        .col_fg    (col_fg),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_rgb   (mix_out)
    );

    assign out_rgb = mix_out;

endmodule

// File: tb/hwcur_top_tb.sv
module hwcur_top_tb;

    localparam logic [3:0] S_IADDR = 4'd0, S_IDATA = 4'd1, S_CADDR = 4'd2,
                           S_CDATA = 4'd3, S_MODE = 4'd4, S_XLO = 4'd5,
                           S_XHI = 4'd6, S_YLO = 4'd7, S_YHI = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [3:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [11:0] pix_x = '0, pix_y = '0;
    logic        pix_blank = 1'b0;
    logic [23:0] pix_rgb = '0;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  img [1024];
    logic [23:0] ctab [3];
    int m_mode = 0, m_il = 0, m_px = 0, m_py = 0;

    hwcur_top u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .pix_x(pix_x), .pix_y(pix_y),
        .pix_blank(pix_blank), .pix_rgb(pix_rgb), .out_rgb(out_rgb)
    );

    always #5 clk = ~clk;

    function automatic logic [23:0] pixval(int x, int y);
        return {x[7:0], y[7:0], 8'h77};
    endfunction

    function automatic logic [23:0] model(int x, int y, bit blank, logic [23:0] pix);
        int py, c, r, b, bt;
        if (blank) return ctab[0];
        if (m_mode != 3) return pix;
        py = m_il ? (m_py & ~1) : m_py;
        c = x + 64 - m_px;
        r = y + 64 - py;
        if (c < 0 || c > 63 || r < 0 || r > 63) return pix;
        b = r * 8 + c / 8;
        bt = 7 - (c % 8);
        if (!img[512 + b][bt]) return pix;
        return img[b][bt] ? ctab[2] : ctab[1];
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hw(logic [3:0] s, logic [7:0] d);
        host_we = 1'b1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic show(string tag, int x, int y, bit blank);
        logic [23:0] exp;
        exp = model(x, y, blank, pixval(x, y));
        pix_x = 12'(x); pix_y = 12'(y); pix_blank = blank; pix_rgb = pixval(x, y);
        @(negedge clk);
        check(tag, out_rgb, exp);
    endtask

    task automatic sweep(string tag, int x0, int x1, int y0, int y1, bit blank);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++)
                show(tag, x, y, blank);
    endtask

    task automatic set_pos(int x, int y);
        hw(S_XLO, 8'(x)); hw(S_XHI, 8'(x >> 8));
        hw(S_YLO, 8'(y)); hw(S_YHI, 8'(y >> 8));
        m_px = x; m_py = y;
    endtask

    task automatic set_mode(logic [7:0] v);
        hw(S_MODE, v);
        m_mode = v[1:0]; m_il = v[3];
    endtask

    task automatic t_reset;
        show("R1 passthru", 10, 20, 0);
        show("R1 blank", 10, 20, 1);
        check("R1 blank zero", out_rgb, 24'h0);
    endtask

    task automatic t_colors;
        logic [7:0] bytes [9];
        bytes = '{8'h10, 8'h20, 8'h30, 8'hA0, 8'hB0, 8'hC0, 8'h0F, 8'h1E, 8'h2D};
        hw(S_CADDR, 8'd0);
        for (int i = 0; i < 9; i++) hw(S_CDATA, bytes[i]);
        ctab[0] = 24'h102030; ctab[1] = 24'hA0B0C0; ctab[2] = 24'h0F1E2D;
        show("R3 overscan entry", 5, 5, 1);
    endtask

    task automatic t_image;
        hw(S_IADDR, 8'd0);
        for (int b = 0; b < 1024; b++) begin
            logic [7:0] v;
            v = (b < 512) ? (8'(b * 91) ^ 8'h5A) : 8'(b * 37 + 5);
            if (b == 0)   v = 8'h80;
            if (b == 512) v = 8'hC0;
            img[b] = v;
            hw(S_IDATA, v);
        end
        // R2: pointer wrapped to 0, so this lands on byte 0
        hw(S_IDATA, 8'h00); img[0] = 8'h00;
        hw(S_IADDR, 8'd5); hw(S_IDATA, 8'hFF); img[5] = 8'hFF;
    endtask

    task automatic t_main;
        set_mode(8'h03);
        set_pos(264, 164);
        // byte 0 = 00 color, byte 512 = C0 mask: col0,col1 background
        show("R2 wrap col0", 200, 100, 0);
        check("R2 wrap col0 bg", out_rgb, 24'hA0B0C0);
        show("R2 msb col2", 202, 100, 0);
        check("R2 msb col2 passthru", out_rgb, pixval(202, 100));
        sweep("R5 R6 window", 198, 265, 98, 165, 0);
    endtask

    task automatic t_recolor;
        hw(S_CADDR, 8'd1);
        for (int i = 0; i < 6; i++) hw(S_CDATA, 8'(8'h41 + i));
        ctab[1] = 24'h414243; ctab[2] = 24'h444546;
        hw(S_CADDR, 8'd7); // 7 -> entry 3 -> treated as 0
        hw(S_CDATA, 8'h01); hw(S_CDATA, 8'h02); hw(S_CDATA, 8'h03);
        ctab[0] = 24'h010203;
        sweep("R3 recolor", 198, 265, 100, 110, 0);
        show("R3 entry3 alias", 0, 0, 1);
    endtask

    task automatic t_commit;
        hw(S_XLO, 8'h2C); // staged only; 300 = 0x12C
        sweep("R7 staged", 190, 310, 100, 101, 0);
        hw(S_XHI, 8'h01); m_px = 300;
        sweep("R7 committed", 190, 310, 100, 101, 0);
    endtask

    task automatic t_partial;
        set_pos(10, 20);
        sweep("R11 partial", 0, 12, 0, 22, 0);
    endtask

    task automatic t_interlace;
        set_pos(264, 165);
        set_mode(8'h0B);
        sweep("R8 interlace", 198, 265, 99, 103, 0);
        sweep("R8 interlace low", 198, 265, 162, 166, 0);
    endtask

    task automatic t_modes;
        set_mode(8'h00);
        sweep("R4 mode0", 198, 230, 100, 102, 0);
        set_mode(8'h01);
        sweep("R4 mode1", 198, 230, 100, 102, 0);
        set_mode(8'h02);
        sweep("R4 mode2", 198, 230, 100, 102, 0);
        set_mode(8'h03);
        sweep("R4 mode3", 198, 230, 100, 102, 0);
    endtask

    task automatic t_blank;
        sweep("R9 blank", 198, 265, 100, 101, 1);
    endtask

    task automatic t_latency;
        logic [23:0] prev, nxt;
        prev = model(300, 300, 0, pixval(300, 300));
        pix_x = 12'd300; pix_y = 12'd300; pix_blank = 0; pix_rgb = pixval(300, 300);
        @(negedge clk);
        check("R10 first", out_rgb, prev);
        nxt = model(0, 0, 1, pixval(0, 0));
        pix_x = 12'd0; pix_y = 12'd0; pix_blank = 1; pix_rgb = pixval(0, 0);
        #2;
        check("R10 before edge", out_rgb, prev);
        @(negedge clk);
        check("R10 after edge", out_rgb, nxt);
        pix_blank = 0;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) ctab[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_colors();
        t_image();
        t_main();
        t_recolor();
        t_commit();
        t_partial();
        t_interlace();
        t_modes();
        t_blank();
        t_latency();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule